// File: doc/BRIEF.md
# Debug Exception Gate and Privilege Router

This block decides, every clock, whether a core may raise a debug exception (hardware breakpoint, watchpoint or single-step) from its present privilege level and security state, and which of the four privilege levels (0 to 3) receives it. It takes as inputs:

- the current level;
- the execution width of the current context and of levels 1 and 3;
- the security state;
- the hypervisor trap controls and the monitor debug controls;
- the kernel debug enable and the debug-mask flag;
- the two OS lock bits.

From these it derives the routing decision.

Besides the enable and the routed level, it outputs two values for the exception entry logic. One is a flag telling that logic whether the exception stays at the current level, which the entry logic places in the syndrome. The other is the destination of a software breakpoint instruction, which always traps. Every output is registered, so the decision for a given set of inputs appears one clock after those inputs are applied.

Top module: `dbg_exc_router`

## Requirements
- R1: The routed level is 2 when `lvl2_on` is 1 and either `hyp_trap_all` or `hyp_trap_dbg` is 1. Otherwise it is 3 when `lvl3_present` is 1, `lvl3_is64` is 0 and `secure` is 1. Otherwise it is 1. The level is encoded as a 2-bit binary number.
- R2: The 64-bit rules apply when the context is 64-bit (`exec_is64`=1). Under these rules, `dbg_en` is 0 whenever the current level is 3.
- R3: Under the 64-bit rules, `mon_sec_dbg_off`=1 together with `secure`=1 forces `dbg_en` to 0.
- R4: Under the 64-bit rules, when neither R2 nor R3 applies, two cases decide `dbg_en`. If the routed level equals the current level, `dbg_en` is `kern_dbg_en` AND NOT `dbg_mask`. Otherwise `dbg_en` is 1 exactly when the routed level is numerically greater than the current level.
- R5: When `os_lock` or `os_dlock` is 1, `dbg_en` is 0 whatever the other inputs are.
- R6: For a 32-bit secure context handled by the 32-bit rules, two cases decide `dbg_en`. At level 0 with `sec_user_dbg_en`=1, `dbg_en` is 1. Otherwise `dbg_en` is 0 only when `mon_sec_dbg_mode` is 2'b10; the values 2'b00, 2'b01 and 2'b11 give 1.
- R7: For a 32-bit non-secure context handled by the 32-bit rules, `dbg_en` is 1 at levels 0, 1 and 3, and 0 at level 2.
- R8: A 32-bit context at level 0 whose level 1 is 64-bit (`lvl1_is64`=1) is judged by the 64-bit rules of R2 to R4, not by R6 or R7.
- R9: `dbg_same_lvl` is 1 exactly when the routed level equals the current level.
- R10: `bkpt_tgt_lvl` is the larger of the routed level and the current level.
- R11: All outputs are registered and reflect the inputs sampled at the previous rising edge. While `rst_n` is low they hold `dbg_en`=0, `dbg_tgt_lvl`=1, `dbg_same_lvl`=0 and `bkpt_tgt_lvl`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_lvl | input | 2 | Current privilege level |
| exec_is64 | input | 1 | Current context executes in 64-bit state |
| lvl1_is64 | input | 1 | Level 1 runs in 64-bit state |
| lvl3_is64 | input | 1 | Level 3 runs in 64-bit state |
| secure | input | 1 | Core is in secure state |
| lvl2_on | input | 1 | Level 2 is enabled in the current security state |
| lvl3_present | input | 1 | Level 3 is implemented |
| hyp_trap_all | input | 1 | Hypervisor control that traps general exceptions to level 2 |
| hyp_trap_dbg | input | 1 | Hypervisor control that traps debug exceptions to level 2 |
| mon_sec_dbg_off | input | 1 | Monitor control disabling debug from secure levels below 3 (64-bit rules) |
| mon_sec_dbg_mode | input | 2 | Monitor secure debug mode for 32-bit rules; 2'b10 disables |
| sec_user_dbg_en | input | 1 | Secure user-level debug always enabled (32-bit rules) |
| kern_dbg_en | input | 1 | Kernel debug enable for same-level exceptions |
| dbg_mask | input | 1 | Processor debug-mask flag |
| os_lock | input | 1 | OS lock status bit |
| os_dlock | input | 1 | OS double-lock bit |
| dbg_en | output | 1 | Debug exceptions may be generated |
| dbg_tgt_lvl | output | 2 | Level receiving debug exceptions |
| dbg_same_lvl | output | 1 | Routed level equals current level (syndrome flag) |
| bkpt_tgt_lvl | output | 2 | Destination level of a software breakpoint instruction |

## Verification
The assertions assume that the inputs are synchronous and change only between rising edges. They compare each registered output against the input values sampled one edge earlier through `$past`, and they qualify that earlier sample with a released reset. Nothing is assumed about the architectural consistency of the inputs: a secure context at level 2 or a non-secure one at level 3 is decoded like any other combination. For that reason the stimulus holds each input vector for exactly one clock and drives it at the falling edge. It sweeps every combination of the sixteen non-lock inputs with both locks clear, including inconsistent combinations. A further pass of scattered vectors covers each nonzero lock setting.

// File: rtl/dbg_route_pkg.sv
package dbg_route_pkg;

    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LVL_USER  = lvl_t'(0);
    localparam lvl_t LVL_KERN  = lvl_t'(1);
    localparam lvl_t LVL_HYP   = lvl_t'(2);
    localparam lvl_t LVL_MON   = lvl_t'(NUM_LVL - 1);

    localparam logic [1:0] SEC_MODE_OFF = 2'b10;

    typedef struct packed {
        logic en;
        lvl_t tgt;
        logic same;
        lvl_t bkpt;
    } route_t;

    localparam route_t ROUTE_RST = '{en: 1'b0, tgt: LVL_KERN, same: 1'b0, bkpt: LVL_KERN};

endpackage

// File: rtl/dbg_target_sel.sv
module dbg_target_sel
    import dbg_route_pkg::*;
(
    input  logic lvl2_on,
    input  logic lvl3_present,
    input  logic lvl3_is64,
    input  logic secure,
    input  logic hyp_trap_all,
    input  logic hyp_trap_dbg,
    input  lvl_t cur_lvl,
    output lvl_t tgt_lvl,
    output logic same_lvl,
    output lvl_t bkpt_lvl
);

    logic to_hyp;
    logic to_mon;

    always_comb begin
        to_hyp = lvl2_on && (hyp_trap_all || hyp_trap_dbg);
        to_mon = lvl3_present && !lvl3_is64 && secure;
        if (to_hyp) begin
            tgt_lvl = LVL_HYP;
        end else if (to_mon) begin
            tgt_lvl = LVL_MON;
        end else begin
            tgt_lvl = LVL_KERN;
        end
        same_lvl = (tgt_lvl == cur_lvl);
        bkpt_lvl = (cur_lvl > tgt_lvl) ? cur_lvl : tgt_lvl;
    end

endmodule

// File: rtl/dbg_enable_eval.sv
module dbg_enable_eval
    import dbg_route_pkg::*;
(
    input  lvl_t       cur_lvl,
    input  lvl_t       tgt_lvl,
    input  logic       exec_is64,
    input  logic       lvl1_is64,
    input  logic       secure,
    input  logic       mon_sec_dbg_off,
    input  logic [1:0] mon_sec_dbg_mode,
    input  logic       sec_user_dbg_en,
    input  logic       kern_dbg_en,
    input  logic       dbg_mask,
    input  logic       os_lock,
    input  logic       os_dlock,
    output logic       en
);

    logic wide_ok;
    logic narrow_ok;
    logic use_wide;
    logic locked;

    // 64-bit rule set
    always_comb begin
        if (cur_lvl == LVL_MON) begin
            wide_ok = 1'b0;
        end else if (secure && mon_sec_dbg_off) begin
            wide_ok = 1'b0;
        end else if (cur_lvl == tgt_lvl) begin
            wide_ok = kern_dbg_en && !dbg_mask;
        end else begin
            wide_ok = (tgt_lvl > cur_lvl);
        end
    end

    // 32-bit rule set
    always_comb begin
        if (!secure) begin
            narrow_ok = (cur_lvl != LVL_HYP);
        end else if ((cur_lvl == LVL_USER) && sec_user_dbg_en) begin
            narrow_ok = 1'b1;
        end else begin
            narrow_ok = (mon_sec_dbg_mode != SEC_MODE_OFF);
        end
    end

    always_comb begin
        use_wide = exec_is64 || ((cur_lvl == LVL_USER) && lvl1_is64);
        locked   = os_lock || os_dlock;
        en       = !locked && (use_wide ? wide_ok : narrow_ok);
    end

endmodule

// File: rtl/dbg_exc_router.sv
module dbg_exc_router
    import dbg_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             exec_is64,
    input  logic             lvl1_is64,
    input  logic             lvl3_is64,
    input  logic             secure,
    input  logic             lvl2_on,
    input  logic             lvl3_present,
    input  logic             hyp_trap_all,
    input  logic             hyp_trap_dbg,
    input  logic             mon_sec_dbg_off,
    input  logic [1:0]       mon_sec_dbg_mode,
    input  logic             sec_user_dbg_en,
    input  logic             kern_dbg_en,
    input  logic             dbg_mask,
    input  logic             os_lock,
    input  logic             os_dlock,
    output logic             dbg_en,
    output logic [LVL_W-1:0] dbg_tgt_lvl,
    output logic             dbg_same_lvl,
    output logic [LVL_W-1:0] bkpt_tgt_lvl
);

    lvl_t   tgt_c;
    lvl_t   bkpt_c;
    logic   same_c;
    logic   en_c;
    route_t route_d;
    route_t route_q;

    dbg_target_sel u_tgt (
        .lvl2_on      (lvl2_on),
        .lvl3_present (lvl3_present),
        .lvl3_is64    (lvl3_is64),
        .secure       (secure),
        .hyp_trap_all (hyp_trap_all),
        .hyp_trap_dbg (hyp_trap_dbg),
        .cur_lvl      (cur_lvl),
        .tgt_lvl      (tgt_c),
        .same_lvl     (same_c),
        .bkpt_lvl     (bkpt_c)
    );

    dbg_enable_eval u_en (
        .cur_lvl          (cur_lvl),
        .tgt_lvl          (tgt_c),
        .exec_is64        (exec_is64),
        .lvl1_is64        (lvl1_is64),
        .secure           (secure),
        .mon_sec_dbg_off  (mon_sec_dbg_off),
        .mon_sec_dbg_mode (mon_sec_dbg_mode),
        .sec_user_dbg_en  (sec_user_dbg_en),
        .kern_dbg_en      (kern_dbg_en),
        .dbg_mask         (dbg_mask),
        .os_lock          (os_lock),
        .os_dlock         (os_dlock),
        .en               (en_c)
    );

    always_comb begin
        route_d      = route_q;
        route_d.en   = en_c;
        route_d.tgt  = tgt_c;
        route_d.same = same_c;
        route_d.bkpt = bkpt_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= ROUTE_RST;
        end else begin
            route_q <= route_d;
        end
    end

    assign dbg_en       = route_q.en;
    assign dbg_tgt_lvl  = route_q.tgt;
    assign dbg_same_lvl = route_q.same;
    assign bkpt_tgt_lvl = route_q.bkpt;

    // R1: hypervisor trap routes to level 2
    a_r1_hyp_route: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && lvl2_on && (hyp_trap_all || hyp_trap_dbg)) |-> (dbg_tgt_lvl == LVL_HYP));

    // R2: no exception from level 3 under 64-bit execution
    a_r2_mon_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exec_is64 && (cur_lvl == LVL_MON)) |-> !dbg_en);

    // R3: secure disable under 64-bit execution
    a_r3_sec_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exec_is64 && secure && mon_sec_dbg_off) |-> !dbg_en);

    // R4: enabled 64-bit exceptions never route downward
    a_r4_no_descent: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n && exec_is64) && dbg_en) |-> (dbg_tgt_lvl >= $past(cur_lvl)));

    // R5: OS locks override everything
    a_r5_lock_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(os_lock || os_dlock) |-> !dbg_en);

    // R7: 32-bit non-secure level 2 is silent
    a_r7_hyp_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!exec_is64 && !secure && (cur_lvl == LVL_HYP)) |-> !dbg_en);

    // R9: same-level flag agrees with routed and previous current level
    a_r9_same_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dbg_same_lvl == (dbg_tgt_lvl == $past(cur_lvl))));

    // R10: breakpoint destination bounds
    a_r10_bkpt_max: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((bkpt_tgt_lvl >= dbg_tgt_lvl) && (bkpt_tgt_lvl >= $past(cur_lvl))
                          && ((bkpt_tgt_lvl == dbg_tgt_lvl) || (bkpt_tgt_lvl == $past(cur_lvl)))));

    // R11: outputs held at reset values after a reset edge
    a_r11_reset_vals: assert property (@(posedge clk)
        $past(!rst_n) |-> (!dbg_en && (dbg_tgt_lvl == LVL_KERN) && !dbg_same_lvl && (bkpt_tgt_lvl == LVL_KERN)));

endmodule

// File: tb/dbg_exc_router_tb_top.sv
module dbg_exc_router_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cur_lvl = '0;
    logic       exec_is64 = 0, lvl1_is64 = 0, lvl3_is64 = 0, secure = 0;
    logic       lvl2_on = 0, lvl3_present = 0, hyp_trap_all = 0, hyp_trap_dbg = 0;
    logic       mon_sec_dbg_off = 0;
    logic [1:0] mon_sec_dbg_mode = '0;
    logic       sec_user_dbg_en = 0, kern_dbg_en = 0, dbg_mask = 0, os_lock = 0, os_dlock = 0;
    logic       dbg_en;
    logic [1:0] dbg_tgt_lvl;
    logic       dbg_same_lvl;
    logic [1:0] bkpt_tgt_lvl;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dbg_exc_router dut_i (
        .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .exec_is64(exec_is64),
        .lvl1_is64(lvl1_is64), .lvl3_is64(lvl3_is64), .secure(secure),
        .lvl2_on(lvl2_on), .lvl3_present(lvl3_present), .hyp_trap_all(hyp_trap_all),
        .hyp_trap_dbg(hyp_trap_dbg), .mon_sec_dbg_off(mon_sec_dbg_off),
        .mon_sec_dbg_mode(mon_sec_dbg_mode), .sec_user_dbg_en(sec_user_dbg_en),
        .kern_dbg_en(kern_dbg_en), .dbg_mask(dbg_mask), .os_lock(os_lock),
        .os_dlock(os_dlock), .dbg_en(dbg_en), .dbg_tgt_lvl(dbg_tgt_lvl),
        .dbg_same_lvl(dbg_same_lvl), .bkpt_tgt_lvl(bkpt_tgt_lvl)
    );

    task automatic apply(input logic [15:0] v, input logic [1:0] lk);
        cur_lvl          = v[1:0];
        exec_is64        = v[2];
        secure           = v[3];
        lvl2_on          = v[4];
        lvl3_present     = v[5];
        hyp_trap_all     = v[6];
        hyp_trap_dbg     = v[7];
        lvl3_is64        = v[8];
        lvl1_is64        = v[9];
        mon_sec_dbg_off  = v[10];
        mon_sec_dbg_mode = v[12:11];
        sec_user_dbg_en  = v[13];
        kern_dbg_en      = v[14];
        dbg_mask         = v[15];
        os_lock          = lk[0];
        os_dlock         = lk[1];
    endtask

    // Independent reference built from the requirement text
    task automatic expect_of(input logic [15:0] v, input logic [1:0] lk,
                             output logic e_en, output int e_tgt, output logic e_same,
                             output int e_bkpt, output string tag);
        int cur;
        cur = int'(v[1:0]);
        if (v[4] && (v[6] || v[7]))            e_tgt = 2;
        else if (v[5] && !v[8] && v[3])        e_tgt = 3;
        else                                   e_tgt = 1;
        e_same = (e_tgt == cur);
        e_bkpt = (cur > e_tgt) ? cur : e_tgt;
        if (lk != 2'b00) begin
            e_en = 0; tag = "R5";
        end else if (v[2] || (cur == 0 && v[9])) begin
            tag = v[2] ? "R4" : "R8";
            if (cur == 3)              begin e_en = 0; tag = "R2"; end
            else if (v[3] && v[10])    begin e_en = 0; tag = "R3"; end
            else if (cur == e_tgt)     e_en = v[14] & ~v[15];
            else                       e_en = (e_tgt > cur);
        end else if (v[3]) begin
            tag = "R6";
            if (cur == 0 && v[13]) e_en = 1;
            else                   e_en = (v[12:11] != 2'd2);
        end else begin
            tag = "R7";
            e_en = (cur != 2);
        end
    endtask

    task automatic check_out(input logic [15:0] v, input logic [1:0] lk);
        logic e_en, e_same;
        int e_tgt, e_bkpt;
        string tag;
        expect_of(v, lk, e_en, e_tgt, e_same, e_bkpt, tag);
        n_vec++;
        if (dbg_en !== e_en) begin
            n_fail++;
            $display("FAIL %s enable v=%h lk=%0d got %0b exp %0b", tag, v, lk, dbg_en, e_en);
        end
        if (int'(dbg_tgt_lvl) != e_tgt) begin
            n_fail++;
            $display("FAIL R1 target v=%h got %0d exp %0d", v, dbg_tgt_lvl, e_tgt);
        end
        if (dbg_same_lvl !== e_same) begin
            n_fail++;
            $display("FAIL R9 same v=%h got %0b exp %0b", v, dbg_same_lvl, e_same);
        end
        if (int'(bkpt_tgt_lvl) != e_bkpt) begin
            n_fail++;
            $display("FAIL R10 bkpt v=%h got %0d exp %0d", v, bkpt_tgt_lvl, e_bkpt);
        end
    endtask

    initial begin
        // R11: reset values, with busy inputs present
        apply(16'hFFFF, 2'b00);
        repeat (3) @(negedge clk);
        n_vec++;
        if (dbg_en !== 1'b0 || dbg_tgt_lvl !== 2'd1 || dbg_same_lvl !== 1'b0 || bkpt_tgt_lvl !== 2'd1) begin
            n_fail++;
            $display("FAIL R11 reset got en=%0b tgt=%0d same=%0b bkpt=%0d exp 0/1/0/1",
                     dbg_en, dbg_tgt_lvl, dbg_same_lvl, bkpt_tgt_lvl);
        end
        rst_n = 1'b1;
        // R11: one-cycle latency, output follows at the next edge
        apply(16'h0000, 2'b00);
        @(negedge clk);
        check_out(16'h0000, 2'b00);
        // Full sweep of non-lock inputs: R1 R2 R3 R4 R6 R7 R8 R9 R10
        for (int i = 0; i < 65536; i++) begin
            apply(16'(i), 2'b00);
            @(negedge clk);
            check_out(16'(i), 2'b00);
        end
        // Lock override sweep: R5
        for (int i = 0; i < 1536; i++) begin
            logic [15:0] v;
            logic [1:0]  lk;
            v  = 16'((i * 40503) ^ (i >> 2));
            lk = 2'((i % 3) + 1);
            apply(v, lk);
            @(negedge clk);
            check_out(v, lk);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule